// File: doc/BRIEF.md
# Multiplexed Converter Serial Command Interface

This block is the digital front of an eight-bit, multi-input converter that a host drives over a byte-wide, full-duplex serial link. Each exchanged byte plays two roles at once. The incoming byte may be a command. The outgoing byte is a result byte, picked by a small counter that tracks how many bytes have passed since the last command. Sample values for every analog input, plus a common reference value, are held in registers. These registers are written from a side load port, which stands in for the analog path.

When a command with its start bit set arrives and power is requested, the block does the following. It picks an input through a select-bit mapping that depends on the variant. It subtracts either the common reference (single-ended) or the input's pair partner (differential). It optionally recodes the result as offset binary. It latches the result split over two response bytes and raises a one-cycle done pulse. The parameter `NUM_INPUTS` chooses a four-input or an eight-input variant.

Top module: `adc_serial_ctrl`

## Requirements
- R1: A byte with bit 7 clear is not a command. It changes no stored command or result, and it does not restart the counter. It is answered as a plain read using the current count.
- R2: A command byte (bit 7 set) with bit 1 clear powers the block down. Every response is 0x00 until a command arrives with bits 7 and 1 both set.
- R3: The eight-input variant selects input {b5,b4,b6} of the command byte, with b5 as the MSB. The four-input variant selects input {b5,b6} and ignores b4.
- R4: With command bit 2 set (single-ended), the measurement is the selected input minus the common register, modulo 256.
- R5: With command bit 2 clear (differential), the measurement is the selected input minus the input whose index differs only in bit 0, modulo 256.
- R6: With command bit 3 clear (bipolar), bit 7 of the measurement is inverted. With bit 3 set, the measurement is passed unchanged.
- R7: A powered command is answered with 0x00. The next byte returns {2'b00, m[7:2]}, the one after returns {m[1:0], 6'b000000}, and every later byte returns 0x00. tx_byte is 0x00 whenever rx_valid is low.
- R8: After reset, input i holds 0xF0 - 0x10*i, the common register is 0, and the block is powered down with a zero count, so responses are 0x00.
- R9: done_pulse is high for exactly the one clock cycle after each powered command is captured. It stays low after power-down commands, non-command bytes and loads.
- R10: When ld_valid is high, ld_data is written on the clock edge. It goes to the common register if ld_common is high, and to input ld_index otherwise. A command in a later cycle uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A byte is exchanged in this cycle |
| rx_byte | input | 8 | Byte received from the host |
| tx_byte | output | 8 | Byte returned to the host in the same cycle |
| ld_valid | input | 1 | Write a sample or reference value |
| ld_common | input | 1 | Target the common reference instead of an input |
| ld_index | input | $clog2(NUM_INPUTS) | Input written when ld_common is low |
| ld_data | input | 8 | Value to write |
| done_pulse | output | 1 | One-cycle pulse after each powered command |

## Verification
The bench walks all eight raw select codes with a zero reference. This reads the reset values back and shows whether the two variants scramble the select bits differently. It then loads distinct input values and runs single-ended and differential commands on every select code. Cases where the subtrahend exceeds the minuend, in both codings, separate a wrong partner, a wrong wrap or a wrong inverted bit. Non-command bytes that resemble commands are placed mid-sequence and during power-down, and back-to-back commands are issued to check that every capture gets its own pulse.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    localparam int BYTE_W = 8;

    // Command byte fields, MSB first; bit positions are decoded by the host.
    typedef struct packed {
        logic start;     // b7
        logic sel2;      // b6
        logic sel1;      // b5
        logic sel0;      // b4
        logic unipolar;  // b3
        logic single;    // b2
        logic pwr_on;    // b1
        logic pwr_aux;   // b0
    } cmd_byte_t;

    function automatic logic [BYTE_W-1:0] reset_sample(input int idx);
        return BYTE_W'(240 - 16 * idx);
    endfunction

endpackage

// File: rtl/adc_sample_bank.sv
module adc_sample_bank
    import adc_ctrl_pkg::*;
#(
    parameter int NUM_INPUTS = 8,
    localparam int IDX_W = $clog2(NUM_INPUTS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ld_valid,
    input  logic                             ld_common,
    input  logic [IDX_W-1:0]                 ld_index,
    input  logic [BYTE_W-1:0]                ld_data,
    output logic [NUM_INPUTS-1:0][BYTE_W-1:0] samples,
    output logic [BYTE_W-1:0]                common
);

    typedef struct packed {
        logic [NUM_INPUTS-1:0][BYTE_W-1:0] chan;
        logic [BYTE_W-1:0]                 common;
    } bank_t;

    bank_t bank_d, bank_q, bank_rst;

    // R8: per-input reset values
    for (genvar g = 0; g < NUM_INPUTS; g++) begin : g_rst
        assign bank_rst.chan[g] = reset_sample(g);
    end
    assign bank_rst.common = '0;

    always_comb begin
        bank_d = bank_q;
        if (ld_valid) begin
            if (ld_common) begin
                bank_d.common = ld_data;
            end else begin
                bank_d.chan[ld_index] = ld_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= bank_rst;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign samples = bank_q.chan;
    assign common  = bank_q.common;

    // R10: loads land on the next edge
    p_common_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && ld_common |=> common == $past(ld_data));
    p_input_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && !ld_common |=> samples[$past(ld_index)] == $past(ld_data));

endmodule

// File: rtl/adc_convert.sv
module adc_convert
    import adc_ctrl_pkg::*;
#(
    parameter int NUM_INPUTS = 8,
    localparam int IDX_W = $clog2(NUM_INPUTS)
) (
    input  cmd_byte_t                         cmd,
    input  logic [NUM_INPUTS-1:0][BYTE_W-1:0] samples,
    input  logic [BYTE_W-1:0]                 common,
    output logic [BYTE_W-1:0]                 meas
);

    logic [IDX_W-1:0]  pick;
    logic [IDX_W-1:0]  partner;
    logic [BYTE_W-1:0] minuend;
    logic [BYTE_W-1:0] subtrahend;
    logic [BYTE_W-1:0] diff;

    // R3: variant-specific select scrambling
    if (NUM_INPUTS == 8) begin : g_sel8
        assign pick = {cmd.sel1, cmd.sel0, cmd.sel2};
    end else begin : g_sel4
        logic unused_sel0;
        assign unused_sel0 = cmd.sel0;
        assign pick = {cmd.sel1, cmd.sel2};
    end

    assign partner = pick ^ IDX_W'(1);

    always_comb begin
        minuend    = samples[pick];
        // R4 / R5: reference choice
        subtrahend = cmd.single ? common : samples[partner];
        diff       = minuend - subtrahend;
        // R6: offset-binary recode
        meas       = cmd.unipolar ? diff : (diff ^ 8'h80);
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] meas,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              done_pulse
);

    localparam logic [1:0] CNT_MAX = 2'd3;

    typedef struct packed {
        cmd_byte_t  cmd;
        logic [1:0] count;
        logic [5:0] hi;
        logic [1:0] lo;
        logic       done;
    } seq_t;

    seq_t      st_d, st_q;
    cmd_byte_t rx_cmd;

    assign rx_cmd = cmd_byte_t'(rx_byte);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        tx_byte   = '0;
        if (rx_valid) begin
            if (rx_cmd.start) begin
                // R7: a command is answered with zero
                st_d.count = (rx_cmd.pwr_on) ? 2'd1 : 2'd0;
                if (rx_cmd.pwr_on) begin
                    st_d.cmd  = rx_cmd;
                    st_d.hi   = meas[7:2];
                    st_d.lo   = meas[1:0];
                    st_d.done = 1'b1;          // R9
                end else begin
                    st_d.cmd  = '0;            // R2
                end
            end else if (st_q.cmd.pwr_on) begin
                // R1: plain read against the current count
                unique case (st_q.count)
                    2'd1:    tx_byte = {2'b00, st_q.hi};
                    2'd2:    tx_byte = {st_q.lo, 6'b000000};
                    default: tx_byte = '0;
                endcase
                if (st_q.count != CNT_MAX) begin
                    st_d.count = st_q.count + 2'd1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_pulse = st_q.done;

    p_cmd_answer_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_byte[7] |-> tx_byte == 8'h00);
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> tx_byte == 8'h00);
    p_down_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_valid && rx_byte[7] && !rx_byte[1]) && !rx_valid |-> tx_byte == 8'h00);
    p_ignore_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_byte[7] |=> $stable(st_q.cmd) && $stable(st_q.hi) && $stable(st_q.lo));
    p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $past(rx_valid && rx_byte[7] && rx_byte[1]));

endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int NUM_INPUTS = 8,
    localparam int IDX_W = $clog2(NUM_INPUTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic [7:0]        tx_byte,
    input  logic              ld_valid,
    input  logic              ld_common,
    input  logic [IDX_W-1:0]  ld_index,
    input  logic [7:0]        ld_data,
    output logic              done_pulse
);

    logic [NUM_INPUTS-1:0][BYTE_W-1:0] samples;
    logic [BYTE_W-1:0]                 common;
    logic [BYTE_W-1:0]                 meas;

    adc_sample_bank #(.NUM_INPUTS(NUM_INPUTS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_common(ld_common),
        .ld_index (ld_index),
        .ld_data  (ld_data),
        .samples  (samples),
        .common   (common)
    );

    adc_convert #(.NUM_INPUTS(NUM_INPUTS)) u_conv (
        .cmd     (cmd_byte_t'(rx_byte)),
        .samples (samples),
        .common  (common),
        .meas    (meas)
    );

    adc_seq_ctrl u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .meas      (meas),
        .tx_byte   (tx_byte),
        .done_pulse(done_pulse)
    );

endmodule

// File: tb/adc_serial_ctrl_test.sv
`timescale 1ns/1ps
module adc_serial_ctrl_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic       rst_n, rx_valid, ld_valid, ld_common;
    logic [7:0] rx_byte, ld_data, tx8, tx4;
    logic [2:0] ld_index;
    logic       done8, done4, ld_valid4;

    assign ld_valid4 = ld_valid && (ld_common || ld_index < 3'd4);

    adc_serial_ctrl #(.NUM_INPUTS(8)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_byte(tx8), .ld_valid(ld_valid), .ld_common(ld_common),
        .ld_index(ld_index), .ld_data(ld_data), .done_pulse(done8));

    adc_serial_ctrl #(.NUM_INPUTS(4)) uut4 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_byte(tx4), .ld_valid(ld_valid4), .ld_common(ld_common),
        .ld_index(ld_index[1:0]), .ld_data(ld_data), .done_pulse(done4));

    int errs = 0, checks = 0;
    bit finished = 0;

    // Behavioural reference: v=0 eight inputs, v=1 four inputs
    int m_in[2][8];
    int m_com[2], m_cnt[2], m_meas[2];
    bit m_pow[2], m_done[2];

    function automatic int nin(int v);
        return (v == 0) ? 8 : 4;
    endfunction

    function automatic int exp_tx(int v, logic [7:0] b);
        if (b[7] || !m_pow[v]) return 0;
        if (m_cnt[v] == 1) return m_meas[v] / 4;
        if (m_cnt[v] == 2) return (m_meas[v] % 4) * 64;
        return 0;
    endfunction

    function automatic void model_step(int v, logic [7:0] b);
        int idx, refv, d;
        m_done[v] = 0;
        if (b[7]) begin
            if (b[1]) begin
                if (v == 0) idx = b[5] * 4 + b[4] * 2 + b[6];
                else        idx = b[5] * 2 + b[6];
                refv = b[2] ? m_com[v] : m_in[v][idx ^ 1];
                d = (m_in[v][idx] - refv + 256) % 256;
                if (!b[3]) d = d ^ 128;
                m_meas[v] = d;
                m_pow[v] = 1; m_cnt[v] = 1; m_done[v] = 1;
            end else begin
                m_pow[v] = 0; m_cnt[v] = 0;
            end
        end else if (m_pow[v] && m_cnt[v] < 3) begin
            m_cnt[v]++;
        end
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic xfer(logic [7:0] b, string tag);
        @(negedge clk);
        rx_byte = b; rx_valid = 1'b1;
        #2;
        chk({tag, " tx8"}, tx8, exp_tx(0, b));
        chk({tag, " tx4"}, tx4, exp_tx(1, b));
        @(posedge clk);
        model_step(0, b); model_step(1, b);
        #2;
        rx_valid = 1'b0;
        chk("R9 done8", done8, m_done[0]);
        chk("R9 done4", done4, m_done[1]);
    endtask

    task automatic load(bit com, int idx, int data);
        @(negedge clk);
        ld_valid = 1'b1; ld_common = com; ld_index = 3'(idx); ld_data = 8'(data);
        @(posedge clk);
        for (int v = 0; v < 2; v++) begin
            if (com) m_com[v] = data;
            else if (idx < nin(v)) m_in[v][idx] = data;
            m_done[v] = 0;
        end
        #2;
        ld_valid = 1'b0;
        chk("R9 load done8", done8, 0);
    endtask

    function automatic logic [7:0] mk(int sel, bit uni, bit sgl, bit pwr);
        return {1'b1, 3'(sel) >> 2 & 3'd1 ? 1'b1 : 1'b0, sel[1], sel[0], uni, sgl, pwr, 1'b0};
    endfunction

    task automatic conv(logic [7:0] cmd, string tag);
        xfer(cmd, tag);
        xfer(8'h00, "R7");
        xfer(8'h00, "R7");
        xfer(8'h00, "R7");
        xfer(8'h00, "R7");
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        #(20 * 20000);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rx_valid = 1'b0; rx_byte = '0;
        ld_valid = 1'b0; ld_common = 1'b0; ld_index = '0; ld_data = '0;
        for (int v = 0; v < 2; v++) begin
            for (int i = 0; i < 8; i++) m_in[v][i] = 240 - 16 * i;
            m_com[v] = 0; m_cnt[v] = 0; m_meas[v] = 0; m_pow[v] = 0; m_done[v] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R8 reset tx", tx8, 0);
        chk("R8 reset done", done8, 0);

        // R8 / R1: non-command after reset answers zero
        xfer(8'h46, "R8");
        xfer(8'h02, "R1");

        // R3 / R8: every raw select code, zero reference, unipolar single-ended
        for (int s = 0; s < 8; s++) conv(mk(s, 1, 1, 1), "R3");

        load(0, 0, 8'h12); load(0, 1, 8'h9C); load(0, 2, 8'h40); load(0, 3, 8'h41);
        load(0, 4, 8'hFF); load(0, 5, 8'h00); load(0, 6, 8'h77); load(0, 7, 8'h80);
        load(1, 0, 8'h35);   // R10

        conv(mk(3, 1, 1, 1), "R4");
        conv(mk(6, 1, 1, 1), "R4");
        conv(mk(3, 0, 1, 1), "R6");
        for (int s = 0; s < 8; s++) conv(mk(s, 1, 0, 1), "R5");
        for (int s = 0; s < 8; s++) conv(mk(s, 0, 0, 1), "R6");

        // R1: look-alike bytes without bit 7 act as reads
        xfer(mk(1, 1, 1, 1), "R1");
        xfer(8'h7F, "R1");
        xfer(8'h02, "R1");
        xfer(8'h4E, "R1");

        // R2: power-down and wake-up
        xfer(8'hC4, "R2");
        xfer(8'h00, "R2");
        xfer(8'h7E, "R2");
        xfer(8'h02, "R2");
        conv(mk(2, 1, 1, 1), "R2");
        xfer(mk(4, 1, 1, 1), "R2");
        xfer(8'h00, "R7");
        xfer(8'h84, "R2");
        xfer(8'h00, "R2");
        xfer(8'h00, "R2");

        // R9: back-to-back commands
        xfer(mk(5, 1, 0, 1), "R9");
        xfer(mk(7, 0, 1, 1), "R9");
        xfer(8'h00, "R7");
        xfer(8'h00, "R7");

        // R10: reload reference and an input, then convert
        load(1, 0, 8'hF0);
        load(0, 6, 8'h05);
        conv(mk(1, 1, 1, 1), "R10");
        conv(mk(5, 1, 1, 1), "R10");

        @(negedge clk);
        chk("R7 idle tx", tx8, 0);
        finished = 1;
        summary();
        $finish;
    end

endmodule